// File: doc/BRIEF.md
# Low-Frequency FSK Tag Waveform Generator

This block stands in for a passive low-frequency tag that answers a reader with a frequency-shift-keyed identity. It drives one coil-control line. A 1 on that line leaves the coil open and a 0 shorts it. Each rising edge of the reader's carrier is presented to the block as a one-cycle strobe. On every strobe the block steps to the next sample of a fixed-length frame. After the last sample it starts the frame again, and it keeps repeating until enable is taken away.

The frame is built from two sub-patterns. One repeats every 8 carrier periods and the other every 10, so the reader sees two distinct field-loading frequencies. The frame opens with a short separator. A start marker follows, made of unit pairs that are deliberately not valid data codes. Then come the 44 identity bits, most significant first. Each bit is a pair of units of different frequency. A short separator comes before every group of four bits.

The identity is written with a one-cycle load. It arrives as a 32-bit upper word and a 32-bit lower word, and only 12 bits of the upper word may be used.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: After reset, and for as long as no identity has been accepted, coil_o is 1 whatever the enable and strobe inputs do.
- R2: An 8-period unit is the sample pattern 1,1,0,0,0,0,0,0 applied 6 times, for 48 samples.
- R3: A 10-period unit is the sample pattern 1,1,1,0,0,0,0,0,0,0 applied 5 times, for 50 samples. No more than 3 consecutive 1 samples ever appear.
- R4: The frame opens with one separator, which is a single 8-sample pattern 1,1,0,0,0,0,0,0. The marker units follow in the order 8,8,8,10,10,10,8,10, where 8 and 10 name the unit period.
- R5: The identity is {id_hi_i[11:0], id_lo_i}. It is sent from bit 43 down to bit 0. A 1 bit is a 10-period unit followed by an 8-period unit, and a 0 bit is an 8-period unit followed by a 10-period unit.
- R6: One separator comes directly before each identity bit whose index modulo 4 is 3, which means before bits 43, 39, …, 3.
- R7: A frame is 4800 samples long (8 + 392 + 88 + 4312). The sample after the last one is the first sample of the frame.
- R8: The frame position moves by exactly one sample per cycle in which carrier_tick_i is 1. Without a strobe, coil_o holds its value.
- R9: While enable_i is 0, coil_o is 1. When enable_i returns to 1, output restarts at the first sample of the frame.
- R10: A load with id_hi_i above 0xFFF is ignored. The stored identity, the armed state and the frame position all stay unchanged. The value 0xFFF itself is accepted.
- R11: An accepted load stores the new identity and restarts the frame at its first sample, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | One-cycle request to store a new identity |
| id_hi_i | input | 32 | Upper identity word; only bits 11:0 may be nonzero |
| id_lo_i | input | 32 | Lower 32 identity bits |
| enable_i | input | 1 | Emission enable |
| carrier_tick_i | input | 1 | One-cycle strobe per carrier rising edge |
| coil_o | output | 1 | Coil control sample: 1 open, 0 shorted |

## Verification
The assertions check the following on every cycle:
- the open coil while disabled or unarmed;
- position hold between strobes;
- the cap of three consecutive high samples;
- restart on an accepted load and immunity to a rejected one;
- the frame closing at exactly 4800 strobes.

Only the bench scenarios can show the content of the frame. They compare every sample of full frames against a model built from R2 to R6. This covers the marker order, the bit pair ordering, the separator placement and the exact 0xFFF boundary.

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen #(
  parameter int ID_W     = 44,
  parameter int HI_W     = 32,
  parameter int LO_W     = 32,
  parameter int F8_LEN   = 8,
  parameter int F8_HIGH  = 2,
  parameter int F8_REPS  = 6,
  parameter int F10_LEN  = 10,
  parameter int F10_HIGH = 3,
  parameter int F10_REPS = 5,
  parameter int GROUP    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [HI_W-1:0] id_hi_i,
  input  logic [LO_W-1:0] id_lo_i,
  input  logic            enable_i,
  input  logic            carrier_tick_i,
  output logic            coil_o
);
  localparam int HI_USED = ID_W - LO_W;
  localparam int SUB_W   = $clog2(F10_LEN + 1);
  localparam int REP_W   = $clog2(F8_REPS + 1);
  localparam int BIT_W   = $clog2(ID_W);
  localparam logic [7:0] MARK_FC10 = 8'hB8;
  localparam bit FIRST_SEP = ((ID_W - 1) % GROUP) == (GROUP - 1);
  localparam int UNIT8  = F8_LEN * F8_REPS;
  localparam int UNIT10 = F10_LEN * F10_REPS;
  localparam int FRAME_LEN = F8_LEN + 4 * UNIT8 + 4 * UNIT10
                           + ((ID_W + GROUP - 1) / GROUP) * F8_LEN
                           + ID_W * (UNIT8 + UNIT10);

  localparam logic [1:0] SEG_LEAD = 2'd0;
  localparam logic [1:0] SEG_MARK = 2'd1;
  localparam logic [1:0] SEG_SEP  = 2'd2;
  localparam logic [1:0] SEG_BIT  = 2'd3;

  logic [ID_W-1:0]  id_q;
  logic             armed;
  logic [1:0]       seg;
  logic [2:0]       mark_idx;
  logic [BIT_W-1:0] bit_idx;
  logic             half;
  logic [SUB_W-1:0] sub;
  logic [REP_W-1:0] rep;

  logic             id_ok, running, cur_bit, unit_fc10;
  logic [SUB_W-1:0] last_sub, hi_len;
  logic [REP_W-1:0] last_rep;
  logic [BIT_W-1:0] nxt_bit;
  logic             sep_next;

  assign id_ok     = (id_hi_i >> HI_USED) == '0;
  assign running   = armed & enable_i;
  assign cur_bit   = id_q[bit_idx];
  assign unit_fc10 = (seg == SEG_MARK) ? MARK_FC10[mark_idx] :
                     (seg == SEG_BIT)  ? (cur_bit ^ half) : 1'b0;
  assign last_sub  = unit_fc10 ? SUB_W'(F10_LEN - 1) : SUB_W'(F8_LEN - 1);
  assign hi_len    = unit_fc10 ? SUB_W'(F10_HIGH) : SUB_W'(F8_HIGH);
  assign last_rep  = (seg == SEG_LEAD || seg == SEG_SEP) ? '0 :
                     unit_fc10 ? REP_W'(F10_REPS - 1) : REP_W'(F8_REPS - 1);
  assign nxt_bit   = bit_idx - BIT_W'(1);
  assign sep_next  = (nxt_bit % BIT_W'(GROUP)) == BIT_W'(GROUP - 1);
  assign coil_o    = running ? (sub < hi_len) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q     <= '0;
      armed    <= 1'b0;
      seg      <= SEG_LEAD;
      mark_idx <= '0;
      bit_idx  <= '0;
      half     <= 1'b0;
      sub      <= '0;
      rep      <= '0;
    end else if ((load_i && id_ok) || !running) begin
      if (load_i && id_ok) begin
        id_q  <= {id_hi_i[HI_USED-1:0], id_lo_i};
        armed <= 1'b1;
      end
      seg      <= SEG_LEAD;
      mark_idx <= '0;
      bit_idx  <= '0;
      half     <= 1'b0;
      sub      <= '0;
      rep      <= '0;
    end else if (carrier_tick_i) begin
      if (sub != last_sub) begin
        sub <= sub + SUB_W'(1);
      end else begin
        sub <= '0;
        if (rep != last_rep) begin
          rep <= rep + REP_W'(1);
        end else begin
          rep <= '0;
          case (seg)
            SEG_LEAD: begin
              seg      <= SEG_MARK;
              mark_idx <= '0;
            end
            SEG_MARK: begin
              if (mark_idx != 3'd7) begin
                mark_idx <= mark_idx + 3'd1;
              end else begin
                bit_idx <= BIT_W'(ID_W - 1);
                half    <= 1'b0;
                seg     <= FIRST_SEP ? SEG_SEP : SEG_BIT;
              end
            end
            SEG_SEP: begin
              seg  <= SEG_BIT;
              half <= 1'b0;
            end
            default: begin
              if (!half) begin
                half <= 1'b1;
              end else if (bit_idx == '0) begin
                seg  <= SEG_LEAD;
                half <= 1'b0;
              end else begin
                bit_idx <= nxt_bit;
                half    <= 1'b0;
                seg     <= sep_next ? SEG_SEP : SEG_BIT;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
  parameter int ID_W     = 44,
  parameter int HI_W     = 32,
  parameter int LO_W     = 32,
  parameter int SUB_W    = 4,
  parameter int REP_W    = 3,
  parameter int F10_HIGH = 3,
  parameter int FRAME    = 4800
) (
  input logic            clk,
  input logic            rst_n,
  input logic            load_i,
  input logic [HI_W-1:0] id_hi_i,
  input logic            enable_i,
  input logic            carrier_tick_i,
  input logic            coil_o,
  input logic            armed,
  input logic [ID_W-1:0] id_q,
  input logic [1:0]      seg,
  input logic [SUB_W-1:0] sub,
  input logic [REP_W-1:0] rep
);
  localparam int HI_USED = ID_W - LO_W;

  logic        load_ok, load_bad, running, at_start;
  logic [15:0] pos_q;
  logic [3:0]  run_q;

  assign load_ok  = load_i && ((id_hi_i >> HI_USED) == '0);
  assign load_bad = load_i && !load_ok;
  assign running  = armed && enable_i;
  assign at_start = (seg == 2'd0) && (sub == '0) && (rep == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      run_q <= '0;
    end else if (load_ok || !running) begin
      pos_q <= '0;
      run_q <= '0;
    end else if (carrier_tick_i) begin
      pos_q <= (pos_q == 16'(FRAME - 1)) ? '0 : pos_q + 16'd1;
      run_q <= coil_o ? ((run_q == 4'hF) ? run_q : run_q + 4'd1) : '0;
    end
  end

  assert_open_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> coil_o);

  assert_high_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 4'(F10_HIGH));

  assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && carrier_tick_i && !load_i && pos_q == 16'(FRAME - 1)) |=> at_start);

  assert_no_early_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && carrier_tick_i && !load_i && pos_q != 16'(FRAME - 1)) |=> !at_start);

  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !carrier_tick_i && !load_i) |=> ($stable(sub) && $stable(rep) && $stable(seg)));

  assert_open_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> coil_o);

  assert_reject_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_bad |=> ($stable(id_q) && $stable(armed)));

  assert_restart_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (at_start && armed));
endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(
  .ID_W(ID_W), .HI_W(HI_W), .LO_W(LO_W), .SUB_W(SUB_W), .REP_W(REP_W),
  .F10_HIGH(F10_HIGH), .FRAME(FRAME_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .id_hi_i(id_hi_i),
  .enable_i(enable_i), .carrier_tick_i(carrier_tick_i), .coil_o(coil_o),
  .armed(armed), .id_q(id_q), .seg(seg), .sub(sub), .rep(rep)
);

// File: tb/fsk_tag_wavegen_tb_top.sv
module fsk_tag_wavegen_tb_top;
  localparam int FRAME = 4800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] id_hi_i = '0;
  logic [31:0] id_lo_i = '0;
  logic        enable_i = 1'b0;
  logic        carrier_tick_i = 1'b0;
  logic        coil_o;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int n = 0;
  bit    ref_s [FRAME];
  string ref_t [FRAME];

  always #10 clk = ~clk;

  fsk_tag_wavegen dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .id_hi_i(id_hi_i),
    .id_lo_i(id_lo_i), .enable_i(enable_i), .carrier_tick_i(carrier_tick_i),
    .coil_o(coil_o)
  );

  task automatic put_unit(bit fc10, int reps, string tag);
    for (int r = 0; r < reps; r++)
      for (int s = 0; s < (fc10 ? 10 : 8); s++) begin
        ref_s[n] = (s < (fc10 ? 3 : 2));
        ref_t[n] = tag;
        n++;
      end
  endtask

  task automatic build(logic [11:0] hi, logic [31:0] lo);
    logic [43:0] id;
    id = {hi, lo};
    n = 0;
    put_unit(0, 1, "R4");
    put_unit(0, 6, "R2"); put_unit(0, 6, "R2");
    put_unit(0, 6, "R2"); put_unit(1, 5, "R3");
    put_unit(1, 5, "R3"); put_unit(1, 5, "R3");
    put_unit(0, 6, "R2"); put_unit(1, 5, "R3");
    for (int i = 43; i >= 0; i--) begin
      if (i % 4 == 3) put_unit(0, 1, "R6");
      if (id[i]) begin
        put_unit(1, 5, "R5"); put_unit(0, 6, "R5");
      end else begin
        put_unit(0, 6, "R5"); put_unit(1, 5, "R5");
      end
    end
  endtask

  task automatic chk(string req, logic exp);
    checks++;
    if (coil_o !== exp) begin
      errors++;
      $display("FAIL %s sample %0d: coil actual=%b expected=%b", req, k, coil_o, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) carrier_tick_i = 1'b1;
    @(negedge clk) carrier_tick_i = 1'b0;
  endtask

  task automatic do_load(logic [31:0] hi, logic [31:0] lo);
    @(negedge clk);
    id_hi_i = hi; id_lo_i = lo; load_i = 1'b1;
    @(negedge clk) load_i = 1'b0;
  endtask

  task automatic compare(int count, string tag);
    for (int j = 0; j < count; j++) begin
      if (k >= FRAME) chk("R7", ref_s[k % FRAME]);
      else chk((tag == "") ? ref_t[k] : tag, ref_s[k]);
      tick();
      k++;
    end
  endtask

  task automatic test_reset();
    chk("R1", 1'b1);
    enable_i = 1'b1;
    for (int j = 0; j < 10; j++) begin tick(); chk("R1", 1'b1); end
  endtask

  task automatic test_reject_first();
    do_load(32'h0000_1000, 32'h1234_5678);
    for (int j = 0; j < 10; j++) begin tick(); chk("R10", 1'b1); end
  endtask

  task automatic test_frame_a();
    build(12'hA5C, 32'h3C96_0F12);
    do_load(32'h0000_0A5C, 32'h3C96_0F12);
    k = 0;
    compare(FRAME + 16, "");
  endtask

  task automatic test_hold();
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R8", ref_s[k % FRAME]);
    end
  endtask

  task automatic test_reject_running();
    do_load(32'hF000_0000, 32'h0);
    compare(300, "R10");
  endtask

  task automatic test_enable_low();
    @(negedge clk) enable_i = 1'b0;
    @(negedge clk);
    for (int j = 0; j < 20; j++) begin chk("R9", 1'b1); tick(); end
    @(negedge clk) enable_i = 1'b1;
    k = 0;
    compare(200, "R9");
  endtask

  task automatic test_reload_b();
    compare(37, "");
    build(12'hFFF, 32'h0000_0001);
    do_load(32'h0000_0FFF, 32'h0000_0001);
    k = 0;
    compare(120, "R11");
    compare(FRAME - 120 + 8, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_reject_first();
    test_frame_a();
    test_hold();
    test_reject_running();
    test_enable_low();
    test_reload_b();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule